// File: doc/BRIEF.md
# Two-Digit Presettable BCD Decade Counter

This block is a synchronous decade counter that steps through the 8421 BCD codes 0 to 9 and then wraps to 0. It is built from one digit cell that is instantiated twice. The carry flag of the low digit feeds the trickle enable of the high digit, so the pair counts 00 to 99 with a single carry path. Typical uses are multi-digit event counters and programmable dividers. For a divider, the pair is preset through the shared parallel-enable input.

Each digit has an active-low parallel enable that loads a four-bit word. It also has two count enables: a parallel enable, which only gates counting, and a trickle enable, which gates both counting and the carry flag. The reset is active low. A build-time parameter selects whether reset clears the count at once or on the next rising edge.

The modes have a fixed precedence: reset, then load, then count, then hold. A load may place an illegal code (10 to 15) in a digit. Every such code returns to the 0 to 9 cycle within two counts.

Top module: `bcd_pair_counter`

## Requirements
- R1: With reset and load inactive and both enables high, each rising edge advances the low digit by one, from 0 up to 8, and from 9 to 0.
- R2: With ASYNC_RST=1, driving rst_n low forces both digits to 0 at once, without waiting for a clock edge.
- R3: With ASYNC_RST=0, rst_n low clears both digits to 0 on the next rising edge, even when load_n is low and both enables are high.
- R4: With rst_n high, load_n low copies din_lo into cnt_lo and din_hi into cnt_hi on the next rising edge, whatever the enables are. Any four-bit value is accepted, including 10 to 15.
- R5: With rst_n and load_n high, if either en_par or en_trk is low, both digits keep their value across the edge.
- R6: carry_lo is 1 exactly when en_trk is 1 and cnt_lo equals 9, and it is 0 in every other state, including 10 to 15.
- R7: In count mode, the illegal codes move as follows: 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15, and 15 to 2. From any of these codes, the digit is back in 0 to 9 within two counts.
- R8: The high digit advances only on an edge where carry_lo and en_par are both 1. Counting therefore runs 00, 01, and so on up to 99, then 00. tc_out is 1 exactly when carry_lo is 1 and cnt_hi equals 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all changes occur on its rising edge except an asynchronous reset |
| rst_n | input | 1 | Active-low reset; timing set by ASYNC_RST |
| load_n | input | 1 | Active-low parallel enable shared by both digits |
| din_lo | input | 4 | Preset value for the low digit |
| din_hi | input | 4 | Preset value for the high digit |
| en_par | input | 1 | Parallel count enable, routed to both digits |
| en_trk | input | 1 | Trickle count enable of the low digit |
| cnt_lo | output | 4 | Low BCD digit |
| cnt_hi | output | 4 | High BCD digit |
| carry_lo | output | 1 | Terminal count of the low digit |
| tc_out | output | 1 | Terminal count of the pair |

## Verification
The count function is tried in four ways:
- An uninterrupted run of more than a hundred counts from 00 shows both the digit wrap at 9 and the carry into the high digit at 99.
- Each of the three enable pairs with a low bit is held over several edges, which separates the hold behaviour from counting and shows that en_trk alone gates the carry flag.
- All sixteen codes are loaded into each digit with the enables high, then counted. This separates load precedence, the fixed map for illegal codes and the two-count recovery bound.
- Two instances, one per reset variant, receive the same stimulus. A reset asserted between edges, and a reset that competes with a load, show whether each clear is immediate or waits for the edge.

// File: rtl/bcd_pair_counter.sv
module bcd_digit #(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic [3:0] din,
  input  logic       en_p,
  input  logic       en_t,
  output logic [3:0] q,
  output logic       tc
);
  logic [3:0] q_inc;
  logic [3:0] q_d;

  always_comb begin
    case (q)
      4'd9:    q_inc = 4'd0;
      4'd10:   q_inc = 4'd11;
      4'd11:   q_inc = 4'd6;
      4'd12:   q_inc = 4'd13;
      4'd13:   q_inc = 4'd4;
      4'd14:   q_inc = 4'd15;
      4'd15:   q_inc = 4'd2;
      default: q_inc = q + 4'd1;
    endcase
  end

  assign q_d = !load_n ? din : ((en_p && en_t) ? q_inc : q);
  assign tc  = en_t && (q == 4'd9);

  generate
    if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end else begin : g_srst
      always_ff @(posedge clk)
        q <= rst_n ? q_d : '0;
    end
  endgenerate
endmodule

module bcd_pair_counter #(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic [3:0] din_lo,
  input  logic [3:0] din_hi,
  input  logic       en_par,
  input  logic       en_trk,
  output logic [3:0] cnt_lo,
  output logic [3:0] cnt_hi,
  output logic       carry_lo,
  output logic       tc_out
);
  bcd_digit #(.ASYNC_RST(ASYNC_RST)) u_lo (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_lo),
    .en_p(en_par), .en_t(en_trk), .q(cnt_lo), .tc(carry_lo)
  );

  bcd_digit #(.ASYNC_RST(ASYNC_RST)) u_hi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_hi),
    .en_p(en_par), .en_t(carry_lo), .q(cnt_hi), .tc(tc_out)
  );
endmodule

// File: rtl/bcd_pair_chk.sv
module bcd_pair_chk #(
  parameter bit ASYNC_RST = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       load_n,
  input logic [3:0] din_lo,
  input logic [3:0] din_hi,
  input logic       en_par,
  input logic       en_trk,
  input logic [3:0] cnt_lo,
  input logic [3:0] cnt_hi,
  input logic       carry_lo,
  input logic       tc_out
);
  // R4
  load_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (cnt_lo == $past(din_lo)) && (cnt_hi == $past(din_hi)));

  // R5
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trk)) |=> $stable(cnt_lo) && $stable(cnt_hi));

  // R1
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk && cnt_lo < 4'd9) |=> cnt_lo == $past(cnt_lo) + 4'd1);

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk && cnt_lo == 4'd9) |=> cnt_lo == 4'd0);

  // R6
  carry_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_lo |-> (en_trk && cnt_lo == 4'd9));

  // R8
  pair_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> (carry_lo && cnt_hi == 4'd9));

  // R7
  illegal_eleven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk && cnt_lo == 4'd11) |=> cnt_lo == 4'd6);

  generate
    if (ASYNC_RST) begin : g_arst_chk
      // R2
      async_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (cnt_lo == 4'd0) && (cnt_hi == 4'd0));
    end
  endgenerate
endmodule

bind bcd_pair_counter bcd_pair_chk #(.ASYNC_RST(ASYNC_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .din_lo(din_lo), .din_hi(din_hi),
  .en_par(en_par), .en_trk(en_trk), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .carry_lo(carry_lo), .tc_out(tc_out)
);

// File: tb/tb_bcd_pair_counter.sv
module tb_bcd_pair_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, load_n, en_par, en_trk;
  logic [3:0] din_lo, din_hi;
  logic [3:0] a_lo, a_hi, s_lo, s_hi;
  logic a_cy, a_tc, s_cy, s_tc;
  logic [3:0] e_lo, e_hi;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_pair_counter #(.ASYNC_RST(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din_lo(din_lo), .din_hi(din_hi),
    .en_par(en_par), .en_trk(en_trk), .cnt_lo(a_lo), .cnt_hi(a_hi),
    .carry_lo(a_cy), .tc_out(a_tc)
  );

  bcd_pair_counter #(.ASYNC_RST(1'b0)) dut_s (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din_lo(din_lo), .din_hi(din_hi),
    .en_par(en_par), .en_trk(en_trk), .cnt_lo(s_lo), .cnt_hi(s_hi),
    .carry_lo(s_cy), .tc_out(s_tc)
  );

  function automatic logic [3:0] next_code(input logic [3:0] q);
    case (q)
      4'd10: return 4'd11;
      4'd11: return 4'd6;
      4'd12: return 4'd13;
      4'd13: return 4'd4;
      4'd14: return 4'd15;
      4'd15: return 4'd2;
      default: return 4'((q + 1) % 10);
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input string req);
    logic cy;
    @(posedge clk);
    cy = en_trk && (e_lo == 4'd9);
    if (!rst_n) begin
      e_lo = 4'd0; e_hi = 4'd0;
    end else if (!load_n) begin
      e_lo = din_lo; e_hi = din_hi;
    end else if (en_par) begin
      if (en_trk) e_lo = next_code(e_lo);
      if (cy)     e_hi = next_code(e_hi);
    end
    @(negedge clk);
    chk(req, {a_hi, a_lo}, {e_hi, e_lo});
    chk(req, {s_hi, s_lo}, {e_hi, e_lo});
    // R6
    chk("R6", {7'd0, a_cy}, {7'd0, en_trk && e_lo == 4'd9});
    // R8
    chk("R8", {7'd0, a_tc}, {7'd0, en_trk && e_lo == 4'd9 && e_hi == 4'd9});
    chk("R8", {s_cy, s_tc}, {a_cy, a_tc});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    e_lo = 4'd0; e_hi = 4'd0;
    rst_n = 1'b0; load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
    din_lo = 4'd0; din_hi = 4'd0;
    cyc("R2"); cyc("R3");
    rst_n = 1'b1;

    // R1 R8: full run through 99 and back to 00
    for (int i = 0; i < 105; i++) cyc("R1");

    // R5: each enable pair with a low bit holds
    for (int m = 0; m < 3; m++) begin
      load_n = 1'b0; din_lo = 4'd9; din_hi = 4'd9; cyc("R4");
      load_n = 1'b1; en_par = m[0]; en_trk = m[1];
      for (int k = 0; k < 3; k++) cyc("R5");
    end
    en_par = 1'b1; en_trk = 1'b1;

    // R4 R7: load every code into each digit and count
    for (int v = 0; v < 16; v++) begin
      load_n = 1'b0; din_lo = 4'(v); din_hi = 4'(15 - v); cyc("R4");
      load_n = 1'b1;
      cyc("R7"); cyc("R7");
      chk("R7", {7'd0, a_lo <= 4'd9}, 8'd1);
      cyc("R7");
    end

    // R6: trickle low with low digit at 9
    load_n = 1'b0; din_lo = 4'd9; din_hi = 4'd3; cyc("R4");
    load_n = 1'b1; en_trk = 1'b0; cyc("R6");
    en_trk = 1'b1; en_par = 1'b0; cyc("R6");
    en_par = 1'b1; cyc("R8");

    // R3: reset beats load and count at the edge
    load_n = 1'b0; din_lo = 4'd5; din_hi = 4'd7; cyc("R4");
    rst_n = 1'b0; din_lo = 4'd2; cyc("R3");
    rst_n = 1'b1; load_n = 1'b1;

    // R2: reset between edges clears only the async variant at once
    load_n = 1'b0; din_lo = 4'd8; din_hi = 4'd3; cyc("R4");
    load_n = 1'b1; en_par = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R2", {a_hi, a_lo}, 8'h00);
    chk("R3", {s_hi, s_lo}, 8'h38);
    cyc("R2");
    rst_n = 1'b1; en_par = 1'b1;
    for (int i = 0; i < 12; i++) cyc("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule